// File: doc/BRIEF.md
# Banked Multi-View Register File

This block holds eight visible 16-bit word registers. Words 0 to 3 are banked: four separate copies exist, and a 2-bit bank select decides which copy occupies those four slots. Words 4 to 7 exist once and are seen by every bank. Word 7 also serves as the stack pointer. Its stored value is always present on a dedicated output.

The same visible storage can be reached at four access sizes. A single bit, a byte, a word, or a 32-bit double word built from an even/odd register pair can each be read or written. There are two combinational read ports and one synchronous write port. Each port carries its own size selector and a shared 7-bit address field whose meaning depends on that size. A write and a read in the same cycle that touch the same storage return the new value on the read port (write-first).

Top module: `banked_regfile`

## Requirements
- R1: After reset every word of every bank and every shared word is zero. All reads and `sp_out` then return zero.
- R2: Words 0..3 come from the bank picked by `bank_sel`. A change of `bank_sel` is visible in the very next combinational read and never alters stored contents.
- R3: A write that lands in words 0..3 changes only the selected bank. The other three banks keep their contents.
- R4: Words 4..7 are common to all banks. A value written there under one bank reads back the same under every bank.
- R5: `sp_out` always equals the stored value of word 7. A write to word 7 shows on `sp_out` only after the clock edge that stores it.
- R6: Size codes are 0 = bit, 1 = byte, 2 = word, 3 = double word. Read data is zero-extended to 32 bits. A word access uses address bits [2:0] as the word index and ignores the upper address bits.
- R7: A byte access uses address bits [3:0] as the byte index. Byte 2n is the low byte of word n and byte 2n+1 is its high byte. A byte write leaves the other byte of that word unchanged.
- R8: A bit access uses address bits [6:4] as the word index and bits [3:0] as the bit position. A bit write stores `wr_data[0]` into that one bit only.
- R9: A double-word access uses address bits [2:0] as the index of the even register, which holds the low half; the next register holds the high half. With an odd index, `wr_illegal` is high in that cycle, the write changes nothing, and a read returns zero.
- R10: Writes take effect on the rising clock edge when `wr_en` is high. Reads are combinational. While a write is presented, both read ports return the file as it will be after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel | input | 2 | Bank occupying words 0..3 |
| wr_en | input | 1 | Write strobe |
| wr_size | input | 2 | Write access size |
| wr_addr | input | 7 | Write address (meaning by size) |
| wr_data | input | 32 | Write data, right-aligned |
| wr_illegal | output | 1 | Misaligned double-word write flag |
| ra_size | input | 2 | Read port A access size |
| ra_addr | input | 7 | Read port A address |
| ra_data | output | 32 | Read port A data, zero-extended |
| rb_size | input | 2 | Read port B access size |
| rb_addr | input | 7 | Read port B address |
| rb_data | output | 32 | Read port B data, zero-extended |
| sp_out | output | 16 | Stored stack-pointer word (word 7) |

## Verification
Read data and `wr_illegal` are combinational. They are due in the same cycle as the inputs that cause them, so the bench drives inputs on the falling edge and compares one nanosecond later. Stored effects of a write, and the matching change on `sp_out`, are due one rising edge after the write is presented. The bench updates its model at that edge and reads back only in later cycles. Bypass checks sample before the edge, and the `sp_out` check also runs both before the edge (old value) and after it (new value).

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;
  typedef enum logic [1:0] {
    ACC_BIT   = 2'd0,
    ACC_BYTE  = 2'd1,
    ACC_WORD  = 2'd2,
    ACC_DWORD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/rf_write_merge.sv
`timescale 1ns/1ps
// Builds the post-write view of the visible words and the per-word enables.
module rf_write_merge import rf_pkg::*; #(
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 8,
  localparam int WIDX_W   = $clog2(NUM_WORDS),
  localparam int BIT_W    = $clog2(WORD_W),
  localparam int LANE_W   = $clog2(WORD_W / 8),
  localparam int ADDR_W   = WIDX_W + BIT_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  acc_size_e                         wr_size,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [2*WORD_W-1:0]               wr_data,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0]  cur_words,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]  nxt_words,
  output logic [NUM_WORDS-1:0]              word_we,
  output logic                              wr_illegal
);
  logic [NUM_WORDS-1:0][WORD_W-1:0] mask_w;
  logic [NUM_WORDS-1:0][WORD_W-1:0] data_w;
  logic [LANE_W-1:0]                lane;

  assign lane       = wr_addr[LANE_W-1:0];
  assign wr_illegal = wr_en && (wr_size == ACC_DWORD) && wr_addr[0];

  always_comb begin
    for (int i = 0; i < NUM_WORDS; i++) begin
      mask_w[i] = '0;
      data_w[i] = '0;
      unique case (wr_size)
        ACC_BIT: begin
          if (wr_addr[BIT_W +: WIDX_W] == WIDX_W'(i))
            mask_w[i] = WORD_W'(1) << wr_addr[BIT_W-1:0];
          data_w[i] = {WORD_W{wr_data[0]}};
        end
        ACC_BYTE: begin
          if (wr_addr[LANE_W +: WIDX_W] == WIDX_W'(i))
            mask_w[i] = WORD_W'(8'hFF) << {lane, 3'b000};
          data_w[i] = {(WORD_W/8){wr_data[7:0]}};
        end
        ACC_WORD: begin
          if (wr_addr[WIDX_W-1:0] == WIDX_W'(i))
            mask_w[i] = '1;
          data_w[i] = wr_data[WORD_W-1:0];
        end
        default: begin
          if (!wr_addr[0] && (wr_addr[WIDX_W-1:1] == (WIDX_W-1)'(i / 2)))
            mask_w[i] = '1;
          data_w[i] = ((i % 2) == 1) ? wr_data[2*WORD_W-1:WORD_W]
                                     : wr_data[WORD_W-1:0];
        end
      endcase
      word_we[i]   = wr_en && (|mask_w[i]);
      nxt_words[i] = word_we[i] ? ((cur_words[i] & ~mask_w[i]) | (data_w[i] & mask_w[i]))
                                : cur_words[i];
    end
  end

  // R9: a misaligned pair enables no word at all
  assert_misaligned_pair_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_illegal |-> (word_we == '0))
    else $error("misaligned double word enabled a word");

  // R7/R8: sub-double accesses touch at most one word
  assert_single_word_touch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_size != ACC_DWORD) |-> $onehot0(word_we))
    else $error("narrow write enabled several words");

  assert_pair_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(word_we) <= 2)
    else $error("more than two words enabled");
endmodule

// File: rtl/rf_read_port.sv
`timescale 1ns/1ps
// One combinational read port over the (post-write) visible words.
module rf_read_port import rf_pkg::*; #(
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 8,
  localparam int WIDX_W   = $clog2(NUM_WORDS),
  localparam int BIT_W    = $clog2(WORD_W),
  localparam int LANE_W   = $clog2(WORD_W / 8),
  localparam int ADDR_W   = WIDX_W + BIT_W
) (
  input  acc_size_e                         rd_size,
  input  logic [ADDR_W-1:0]                 rd_addr,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0]  words,
  output logic [2*WORD_W-1:0]               rd_data
);
  logic [WORD_W-1:0] byte_word;
  logic [LANE_W-1:0] lane;

  assign lane      = rd_addr[LANE_W-1:0];
  assign byte_word = words[rd_addr[LANE_W +: WIDX_W]];

  always_comb begin
    rd_data = '0;
    unique case (rd_size)
      ACC_BIT:  rd_data[0]        = words[rd_addr[BIT_W +: WIDX_W]][rd_addr[BIT_W-1:0]];
      ACC_BYTE: rd_data[7:0]      = byte_word[{lane, 3'b000} +: 8];
      ACC_WORD: rd_data[WORD_W-1:0] = words[rd_addr[WIDX_W-1:0]];
      default: begin
        if (!rd_addr[0])
          rd_data = {words[{rd_addr[WIDX_W-1:1], 1'b1}], words[{rd_addr[WIDX_W-1:1], 1'b0}]};
      end
    endcase
  end
endmodule

// File: rtl/rf_bank_store.sv
`timescale 1ns/1ps
// Banked lower words plus shared upper words, with per-word clock enables.
module rf_bank_store #(
  parameter int WORD_W     = 16,
  parameter int NUM_WORDS  = 8,
  parameter int NUM_BANKED = 4,
  parameter int NUM_BANKS  = 4,
  localparam int BSEL_W     = $clog2(NUM_BANKS),
  localparam int NUM_SHARED = NUM_WORDS - NUM_BANKED,
  localparam int FLAT_W     = (NUM_BANKS * NUM_BANKED + NUM_SHARED) * WORD_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [BSEL_W-1:0]                 bank_sel,
  input  logic [NUM_WORDS-1:0]              word_we,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0]  word_nxt,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]  vis_words,
  output logic [FLAT_W-1:0]                 store_flat
);
  logic [NUM_BANKS-1:0][NUM_BANKED-1:0][WORD_W-1:0] bank_q;
  logic [NUM_SHARED-1:0][WORD_W-1:0]                shared_q;
  logic [NUM_BANKS-1:0][NUM_BANKED-1:0]             bank_we;
  logic [NUM_SHARED-1:0]                            shared_we;

  // next-state enables
  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++)
      for (int i = 0; i < NUM_BANKED; i++)
        bank_we[b][i] = word_we[i] && (bank_sel == BSEL_W'(b));
    for (int s = 0; s < NUM_SHARED; s++)
      shared_we[s] = word_we[NUM_BANKED + s];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q   <= '0;
      shared_q <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++)
        for (int i = 0; i < NUM_BANKED; i++)
          if (bank_we[b][i]) bank_q[b][i] <= word_nxt[i];
      for (int s = 0; s < NUM_SHARED; s++)
        if (shared_we[s]) shared_q[s] <= word_nxt[NUM_BANKED + s];
    end
  end

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_vis
    if (i < NUM_BANKED) begin : g_banked
      assign vis_words[i] = bank_q[bank_sel][i];
    end else begin : g_shared
      assign vis_words[i] = shared_q[i - NUM_BANKED];
    end
  end

  assign store_flat = {bank_q, shared_q};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    // R3: a bank that is not selected keeps its contents
    assert_idle_bank_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_sel != BSEL_W'(b)) |=> $stable(bank_q[b]))
      else $error("unselected bank %0d changed", b);
  end

  // R4: shared words change only through an enabled write
  assert_shared_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_we[NUM_WORDS-1:NUM_BANKED] == '0) |=> $stable(shared_q))
    else $error("shared word changed without a write");
endmodule

// File: rtl/banked_regfile.sv
`timescale 1ns/1ps
module banked_regfile import rf_pkg::*; #(
  parameter int WORD_W     = 16,
  parameter int NUM_WORDS  = 8,
  parameter int NUM_BANKED = 4,
  parameter int NUM_BANKS  = 4,
  localparam int BSEL_W     = $clog2(NUM_BANKS),
  localparam int ADDR_W     = $clog2(NUM_WORDS) + $clog2(WORD_W),
  localparam int DATA_W     = 2 * WORD_W,
  localparam int NUM_SHARED = NUM_WORDS - NUM_BANKED,
  localparam int FLAT_W     = (NUM_BANKS * NUM_BANKED + NUM_SHARED) * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BSEL_W-1:0] bank_sel,
  input  logic              wr_en,
  input  logic [1:0]        wr_size,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_illegal,
  input  logic [1:0]        ra_size,
  input  logic [ADDR_W-1:0] ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [1:0]        rb_size,
  input  logic [ADDR_W-1:0] rb_addr,
  output logic [DATA_W-1:0] rb_data,
  output logic [WORD_W-1:0] sp_out
);
  logic                             rst_meta_n, rst_sync_n;
  logic [NUM_WORDS-1:0][WORD_W-1:0] cur_words, nxt_words;
  logic [NUM_WORDS-1:0]             word_we;
  logic [FLAT_W-1:0]                store_flat;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  rf_bank_store #(
    .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .NUM_BANKED(NUM_BANKED), .NUM_BANKS(NUM_BANKS)
  ) u_store (
    .clk(clk), .rst_n(rst_sync_n), .bank_sel(bank_sel), .word_we(word_we),
    .word_nxt(nxt_words), .vis_words(cur_words), .store_flat(store_flat)
  );

  rf_write_merge #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_merge (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_size(acc_size_e'(wr_size)),
    .wr_addr(wr_addr), .wr_data(wr_data), .cur_words(cur_words),
    .nxt_words(nxt_words), .word_we(word_we), .wr_illegal(wr_illegal)
  );

  // both read ports see the post-write view: write-first bypass
  rf_read_port #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_rd_a (
    .rd_size(acc_size_e'(ra_size)), .rd_addr(ra_addr), .words(nxt_words), .rd_data(ra_data)
  );
  rf_read_port #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_rd_b (
    .rd_size(acc_size_e'(rb_size)), .rd_addr(rb_addr), .words(nxt_words), .rd_data(rb_data)
  );

  assign sp_out = cur_words[NUM_WORDS-1];

  // R9: a flagged double-word write leaves all storage untouched
  assert_illegal_no_store_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_illegal |=> $stable(store_flat))
    else $error("flagged write modified storage");

  // R5: the stack pointer moves only on a write
  assert_sp_hold_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_en |=> $stable(sp_out))
    else $error("stack pointer changed without a write");

  // R10: same-word read during a word write returns the new data
  assert_word_bypass_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_size == 2'd2 && ra_size == 2'd2 &&
     ra_addr[$clog2(NUM_WORDS)-1:0] == wr_addr[$clog2(NUM_WORDS)-1:0])
    |-> (ra_data == {{WORD_W{1'b0}}, wr_data[WORD_W-1:0]}))
    else $error("write-first bypass missing");
endmodule

// File: tb/banked_regfile_bench.sv
`timescale 1ns/1ps
module banked_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  bank_sel;
  logic        wr_en;
  logic [1:0]  wr_size;
  logic [6:0]  wr_addr;
  logic [31:0] wr_data;
  logic        wr_illegal;
  logic [1:0]  ra_size, rb_size;
  logic [6:0]  ra_addr, rb_addr;
  logic [31:0] ra_data, rb_data;
  logic [15:0] sp_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [15:0] mb [4][4];
  logic [15:0] ms [4];

  always #5 clk = ~clk;

  banked_regfile u_banked_regfile (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .wr_en(wr_en), .wr_size(wr_size),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_illegal(wr_illegal),
    .ra_size(ra_size), .ra_addr(ra_addr), .ra_data(ra_data),
    .rb_size(rb_size), .rb_addr(rb_addr), .rb_data(rb_data), .sp_out(sp_out)
  );

  function automatic logic [15:0] mget(int w);
    return (w < 4) ? mb[bank_sel][w] : ms[w-4];
  endfunction

  task automatic mput(int w, logic [15:0] v);
    if (w < 4) mb[bank_sel][w] = v; else ms[w-4] = v;
  endtask

  function automatic logic [31:0] exp_read(int sz, int addr);
    logic [15:0] v;
    logic [31:0] r;
    r = '0;
    case (sz)
      0: begin v = mget(addr / 16); r[0] = v[addr % 16]; end
      1: begin v = mget((addr % 16) / 2); r[7:0] = (addr % 2 == 1) ? v[15:8] : v[7:0]; end
      2: r[15:0] = mget(addr % 8);
      default: if (addr % 2 == 0) r = {mget(addr % 8 + 1), mget(addr % 8)};
    endcase
    return r;
  endfunction

  task automatic model_write(int sz, int addr, logic [31:0] d);
    logic [15:0] v;
    int w;
    case (sz)
      0: begin w = addr / 16; v = mget(w); v[addr % 16] = d[0]; mput(w, v); end
      1: begin
        w = (addr % 16) / 2; v = mget(w);
        if (addr % 2 == 1) v[15:8] = d[7:0]; else v[7:0] = d[7:0];
        mput(w, v);
      end
      2: mput(addr % 8, d[15:0]);
      default: if (addr % 2 == 0) begin
        mput(addr % 8, d[15:0]);
        mput(addr % 8 + 1, d[31:16]);
      end
    endcase
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // plain write, committed at the next rising edge
  task automatic do_write(int sz, int addr, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_size = 2'(sz); wr_addr = 7'(addr); wr_data = d;
    #1 chk("R9 flag", {31'b0, wr_illegal}, {31'b0, (sz == 3) && (addr % 2 == 1)});
    @(posedge clk);
    model_write(sz, addr, d);
    #1 wr_en = 1'b0;
  endtask

  // write with both ports looking at it before the edge
  task automatic do_write_bypass(int sz, int addr, logic [31:0] d, int wordb);
    logic [15:0] sp_old;
    @(negedge clk);
    wr_en = 1'b1; wr_size = 2'(sz); wr_addr = 7'(addr); wr_data = d;
    ra_size = 2'(sz); ra_addr = 7'(addr);
    rb_size = 2'd2;   rb_addr = 7'(wordb);
    sp_old = ms[3];
    #1;
    chk("R5 before edge", {16'b0, sp_out}, {16'b0, sp_old});
    model_write(sz, addr, d);
    chk("R10 port A bypass", ra_data, exp_read(sz, addr));
    chk("R10 port B bypass", rb_data, exp_read(2, wordb));
    @(posedge clk);
    #1 wr_en = 1'b0;
    chk("R5 after edge", {16'b0, sp_out}, {16'b0, ms[3]});
  endtask

  task automatic rd2(string req, int sza, int addra, int szb, int addrb);
    @(negedge clk);
    wr_en = 1'b0;
    ra_size = 2'(sza); ra_addr = 7'(addra);
    rb_size = 2'(szb); rb_addr = 7'(addrb);
    #1;
    chk(req, ra_data, exp_read(sza, addra));
    chk(req, rb_data, exp_read(szb, addrb));
  endtask

  task automatic sel_bank(int b);
    @(negedge clk);
    bank_sel = 2'(b);
  endtask

  task automatic read_all(string req);
    for (int w = 0; w < 8; w++) rd2(req, 2, w, 3, w);
    chk("R5 sp", {16'b0, sp_out}, {16'b0, ms[3]});
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bank_sel = '0; wr_en = 1'b0; wr_size = '0; wr_addr = '0; wr_data = '0;
    ra_size = '0; ra_addr = '0; rb_size = '0; rb_addr = '0;
    for (int b = 0; b < 4; b++) for (int w = 0; w < 4; w++) mb[b][w] = '0;
    for (int s = 0; s < 4; s++) ms[s] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: everything zero in every bank
    for (int b = 0; b < 4; b++) begin
      sel_bank(b);
      read_all("R1 reset");
    end

    // R2/R3/R4/R6: word writes per bank, upper address bits set and ignored
    for (int b = 0; b < 4; b++) begin
      sel_bank(b);
      for (int w = 0; w < 8; w++)
        do_write(2, w + 8 * ((b + w) % 16), 32'hFFFF_0000 | ((b * 32'h1111) ^ (w * 32'h0203) ^ 32'h5A00));
    end
    for (int b = 0; b < 4; b++) begin
      sel_bank(b);
      read_all("R2 R3 R4 R6 bank view");
    end
    sel_bank(3); sel_bank(0); sel_bank(2);
    read_all("R2 switch keeps data");

    // R7: byte sweep in bank 2
    for (int i = 0; i < 16; i++) begin
      do_write(1, i, 32'hABCD_EF00 | ((i * 17 + 3) % 256));
      rd2("R7 byte", 1, i, 2, i / 2);
    end
    for (int i = 0; i < 16; i++) rd2("R7 byte reread", 1, i, 1, 15 - i);

    // R8: toggle every bit in bank 1
    sel_bank(1);
    for (int i = 0; i < 128; i++) begin
      do_write(0, i, {31'h7FFF_FFFF, ~exp_read(0, i)});
      rd2("R8 bit", 0, i, 2, i / 16);
    end
    sel_bank(0);
    read_all("R3 bank0 after bit sweep");

    // R9: aligned pairs, then misaligned ones
    sel_bank(3);
    for (int w = 0; w < 8; w += 2) begin
      do_write(3, w, 32'h1357_0000 + w * 32'h0101_0101);
      rd2("R9 pair", 3, w, 2, w + 1);
    end
    for (int w = 1; w < 8; w += 2) begin
      do_write(3, w, 32'hDEAD_BEEF);
      rd2("R9 odd read zero", 3, w, 3, w - 1);
    end
    read_all("R9 odd writes suppressed");

    // R10 and R5: write-first bypass at every size, stack pointer timing
    for (int b = 0; b < 4; b++) begin
      sel_bank(b);
      do_write_bypass(2, 7, 32'h0000_1000 + b * 32'h0111, 7);
      do_write_bypass(2, b, 32'h0000_C0DE ^ b, b);
      do_write_bypass(1, 2 * b + 1, 32'h0000_00A5 + b, b);
      do_write_bypass(0, 16 * b + 5, b % 2, b);
      do_write_bypass(3, 4, 32'h8765_4321 + b, 5);
      do_write_bypass(3, 5, 32'h0F0F_0F0F, 4);
    end
    for (int b = 0; b < 4; b++) begin
      sel_bank(b);
      read_all("R3 R4 R10 final");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule